// File: doc/BRIEF.md
# Power-Down Mode Sequencer

This block moves a small processor core between normal operation and two power-down depths. The shallow depth is a light sleep: it halts only the CPU clock and leaves the main oscillator and every peripheral running. The deep depth is a full stop: it switches the main oscillator off and freezes the interval timer. The event timer stays clocked in stop only when it counts an external input. The watch timer and the LCD clock never stop.

The CPU asks for a depth with a one-cycle request. At entry the block captures the interrupt enable vector, the event-timer external-mode flag and the start-up period select. Only sources whose enable was captured at entry can wake the core. Each depth accepts a different set of sources. A wake from light sleep returns straight to run. A wake from stop turns the oscillator back on and then waits a counted number of sub-clock ticks with the CPU still gated. At the end of that wait a one-cycle ready pulse marks the resumption of the CPU clock. An asynchronous reset returns the block to run from any state and emits a register-reinitialisation pulse. An interrupt wake never emits that pulse.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: In the stop state `osc_main_en`, `cpu_clk_en` and `bit_clk_en` are all 0, and they stay 0 until a qualifying wake.
- R2: In the sleep state `cpu_clk_en` is 0, while `osc_main_en`, `bit_clk_en` and `evt_clk_en` are all 1.
- R3: `watch_clk_en` and `lcd_clk_en` are 1 in every state once reset has been released.
- R4: In stop, `evt_clk_en` equals the value of `evt_ext_mode` captured on the cycle the stop request was accepted. Later changes of that input have no effect.
- R5: With the default masks, the stop state is left for bit positions 0 (serial), 1 (watch timer) and 4 (external pin) of `irq_req`. Positions 2 and 3 (event channels) leave stop only when external mode was captured. Position 5 (interval timer) never leaves stop.
- R6: In sleep, any source whose captured enable is 1 returns the block to run at the next clock edge, and `cpu_clk_en` is 1 after that edge.
- R7: The `irq_en` vector is captured when a request is accepted. Enables set after entry do not wake the block.
- R8: After a stop wake, `cpu_clk_en` stays 0 for one edge plus (WARM_BASE << sel) edges on which `sub_tick` is 1, where sel is `warm_sel` captured at stop entry. Edges with `sub_tick` at 0 do not advance the wait.
- R9: `clk_ready` is a single-cycle pulse that is 1 in the first cycle in which the CPU clock resumes after a stop. It stays 0 on a sleep wake.
- R10: An entry request is accepted only in run with no pending enabled interrupt (`irq_req & irq_en` all zero). Otherwise it is dropped. When both requests are 1, stop wins.
- R11: While `rst_n` is 0 the block is in run and `reg_rst_pulse` is 1. The pulse clears at the first clock edge after release. An interrupt wake never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to enter light sleep |
| stop_req | input | 1 | One-cycle request to enter deep stop |
| irq_req | input | N_SRC | Per-source interrupt request levels |
| irq_en | input | N_SRC | Per-source interrupt enables |
| evt_ext_mode | input | 1 | Event timer is counting an external input |
| warm_sel | input | SEL_W | Start-up period select, period = WARM_BASE << sel |
| sub_tick | input | 1 | One-cycle strobe from the free-running sub-clock |
| osc_main_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| bit_clk_en | output | 1 | Interval timer clock gate |
| evt_clk_en | output | 1 | Event timer clock gate |
| watch_clk_en | output | 1 | Watch timer clock gate |
| lcd_clk_en | output | 1 | LCD driver clock gate |
| reg_rst_pulse | output | 1 | Control-register reinitialisation pulse |
| clk_ready | output | 1 | One-cycle pulse at the end of the start-up wait |

## Verification
The bench builds the block with WARM_BASE = 2 and keeps the six-source default masks, so the four start-up periods are 2, 4, 8 and 16 ticks. At that size the bench sweeps every combination of period select, external-mode flag and single enabled source through a full stop entry and wake, and checks each exact resume latency. It also takes every source through a sleep wake. Directed cases cover enables set after entry, dropped requests, request priority, gaps in the sub-clock tick and reset out of a power-down state.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_SLEEP = 2'd1,
      PM_STOP  = 2'd2,
      PM_WARM  = 2'd3
   } pm_state_e;

   typedef struct packed {
      logic osc;
      logic cpu;
      logic itv;
      logic evt;
      logic wch;
      logic lcd;
   } gate_s;

endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
   parameter int               N_SRC   = 6,
   parameter logic [N_SRC-1:0] STOP_OK = 6'b010011,
   parameter logic [N_SRC-1:0] EVT_SRC = 6'b001100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [N_SRC-1:0] irq_req,
   input  logic [N_SRC-1:0] irq_en,
   input  logic             evt_ext_in,
   output logic             pend_live,
   output logic             wake_light,
   output logic             wake_deep,
   output logic             evt_ext_q
);

   logic [N_SRC-1:0] en_q;
   logic [N_SRC-1:0] deep_ok;
   logic [N_SRC-1:0] armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= '0;
         evt_ext_q <= 1'b0;
      end else if (capture) begin
         en_q      <= irq_en;
         evt_ext_q <= evt_ext_in;
      end
   end

   // per-source deep-stop eligibility, fixed by the masks at elaboration
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (STOP_OK[i]) begin : g_always
         assign deep_ok[i] = 1'b1;
      end else if (EVT_SRC[i]) begin : g_ext
         assign deep_ok[i] = evt_ext_q;
      end else begin : g_never
         assign deep_ok[i] = 1'b0;
      end
   end

   assign armed      = irq_req & en_q;
   assign pend_live  = |(irq_req & irq_en);
   assign wake_light = |armed;
   assign wake_deep  = |(armed & deep_ok);

endmodule

// File: rtl/pmc_warm_cnt.sv
module pmc_warm_cnt #(
   parameter int WARM_BASE = 1024,
   parameter int SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             start,
   input  logic             active,
   input  logic             tick,
   output logic             done
);

   localparam int MAX_SEL = (1 << SEL_W) - 1;
   localparam int MAX_CNT = WARM_BASE << MAX_SEL;
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] base_v;

   assign base_v = CNT_W'(WARM_BASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (arm) begin
         sel_q <= sel_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= base_v << sel_q;
      end else if (active && tick && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = active && tick && (cnt == CNT_W'(1));

endmodule

// File: rtl/pmc_gate_dec.sv
module pmc_gate_dec
   import pmc_pkg::*;
(
   input  pm_state_e st,
   input  logic      evt_ext,
   output gate_s     g
);

   always_comb begin
      g     = '{osc: 1'b1, cpu: 1'b1, itv: 1'b1, evt: 1'b1, wch: 1'b1, lcd: 1'b1};
      unique case (st)
         PM_RUN: ;
         PM_SLEEP: begin
            g.cpu = 1'b0;
         end
         PM_STOP: begin
            g.osc = 1'b0;
            g.cpu = 1'b0;
            g.itv = 1'b0;
            g.evt = evt_ext;
         end
         PM_WARM: begin
            g.cpu = 1'b0;
            g.evt = evt_ext;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int               N_SRC     = 6,
   parameter logic [N_SRC-1:0] STOP_OK   = 6'b010011,
   parameter logic [N_SRC-1:0] EVT_SRC   = 6'b001100,
   parameter int               WARM_BASE = 1024,
   parameter int               SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             stop_req,
   input  logic [N_SRC-1:0] irq_req,
   input  logic [N_SRC-1:0] irq_en,
   input  logic             evt_ext_mode,
   input  logic [SEL_W-1:0] warm_sel,
   input  logic             sub_tick,
   output logic             osc_main_en,
   output logic             cpu_clk_en,
   output logic             bit_clk_en,
   output logic             evt_clk_en,
   output logic             watch_clk_en,
   output logic             lcd_clk_en,
   output logic             reg_rst_pulse,
   output logic             clk_ready
);

   if (N_SRC < 1) begin : g_bad_src
      $error("pwr_mode_ctrl: N_SRC must be at least 1");
   end
   if (WARM_BASE < 1) begin : g_bad_base
      $error("pwr_mode_ctrl: WARM_BASE must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("pwr_mode_ctrl: SEL_W must be 1 to 4");
   end
   if ((STOP_OK & EVT_SRC) != '0) begin : g_bad_mask
      $error("pwr_mode_ctrl: a source cannot be in both stop masks");
   end

   pm_state_e state, state_nx;
   logic      enter, go_stop, go_sleep;
   logic      pend_live, wake_light, wake_deep, evt_ext_q;
   logic      warm_start, warm_done;
   gate_s     gates;

   assign enter    = (state == PM_RUN) && !pend_live && (stop_req || sleep_req);
   assign go_stop  = enter && stop_req;
   assign go_sleep = enter && !stop_req;

   assign warm_start = (state == PM_STOP) && wake_deep;

   pmc_wake_qual #(
      .N_SRC   (N_SRC),
      .STOP_OK (STOP_OK),
      .EVT_SRC (EVT_SRC)
   ) u_wake (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (enter),
      .irq_req    (irq_req),
      .irq_en     (irq_en),
      .evt_ext_in (evt_ext_mode),
      .pend_live  (pend_live),
      .wake_light (wake_light),
      .wake_deep  (wake_deep),
      .evt_ext_q  (evt_ext_q)
   );

   pmc_warm_cnt #(
      .WARM_BASE (WARM_BASE),
      .SEL_W     (SEL_W)
   ) u_warm (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (go_stop),
      .sel_in (warm_sel),
      .start  (warm_start),
      .active (state == PM_WARM),
      .tick   (sub_tick),
      .done   (warm_done)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         PM_RUN: begin
            if (go_stop)       state_nx = PM_STOP;
            else if (go_sleep) state_nx = PM_SLEEP;
         end
         PM_SLEEP: if (wake_light) state_nx = PM_RUN;
         PM_STOP:  if (wake_deep)  state_nx = PM_WARM;
         PM_WARM:  if (warm_done)  state_nx = PM_RUN;
         default:  state_nx = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= PM_RUN;
         clk_ready     <= 1'b0;
         reg_rst_pulse <= 1'b1;
      end else begin
         state         <= state_nx;
         clk_ready     <= warm_done;
         reg_rst_pulse <= 1'b0;
      end
   end

   pmc_gate_dec u_gate (
      .st      (state),
      .evt_ext (evt_ext_q),
      .g       (gates)
   );

   assign osc_main_en  = gates.osc;
   assign cpu_clk_en   = gates.cpu;
   assign bit_clk_en   = gates.itv;
   assign evt_clk_en   = gates.evt;
   assign watch_clk_en = gates.wch;
   assign lcd_clk_en   = gates.lcd;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
   input logic clk,
   input logic rst_n,
   input logic osc_main_en,
   input logic cpu_clk_en,
   input logic bit_clk_en,
   input logic watch_clk_en,
   input logic lcd_clk_en,
   input logic reg_rst_pulse,
   input logic clk_ready
);

   // R1: oscillator off implies CPU and interval timer gated
   p_osc_off_gates_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_main_en |-> (!cpu_clk_en && !bit_clk_en));

   // R3: always-on domains
   p_always_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      watch_clk_en && lcd_clk_en);

   // R8: CPU cannot resume in the cycle right after a stop
   p_no_direct_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_main_en |=> !cpu_clk_en);

   // R9: ready is a single-cycle pulse
   p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_ready |=> !clk_ready);

   // R9: ready coincides with CPU clock resumption
   p_ready_with_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_ready |-> (cpu_clk_en && $past(!cpu_clk_en)));

   // R11: register pulse only right after reset
   p_rst_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rst_pulse |=> !reg_rst_pulse);

endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .osc_main_en   (osc_main_en),
   .cpu_clk_en    (cpu_clk_en),
   .bit_clk_en    (bit_clk_en),
   .watch_clk_en  (watch_clk_en),
   .lcd_clk_en    (lcd_clk_en),
   .reg_rst_pulse (reg_rst_pulse),
   .clk_ready     (clk_ready)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

   localparam int N   = 6;
   localparam int BSE = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sleep_req = 1'b0, stop_req = 1'b0;
   logic [N-1:0] irq_req = '0, irq_en = '0;
   logic         evt_ext_mode = 1'b0;
   logic [1:0]   warm_sel = 2'd0;
   logic         sub_tick = 1'b1;
   logic         osc_main_en, cpu_clk_en, bit_clk_en, evt_clk_en;
   logic         watch_clk_en, lcd_clk_en, reg_rst_pulse, clk_ready;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pwr_mode_ctrl #(.N_SRC(N), .WARM_BASE(BSE), .SEL_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stop_req(stop_req),
      .irq_req(irq_req), .irq_en(irq_en), .evt_ext_mode(evt_ext_mode),
      .warm_sel(warm_sel), .sub_tick(sub_tick), .osc_main_en(osc_main_en),
      .cpu_clk_en(cpu_clk_en), .bit_clk_en(bit_clk_en), .evt_clk_en(evt_clk_en),
      .watch_clk_en(watch_clk_en), .lcd_clk_en(lcd_clk_en),
      .reg_rst_pulse(reg_rst_pulse), .clk_ready(clk_ready));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; sleep_req = 1'b0; stop_req = 1'b0;
      irq_req = '0; irq_en = '0; sub_tick = 1'b1;
      @(negedge clk);
      chk(reg_rst_pulse == 1'b1, "R11 pulse in reset", int'(reg_rst_pulse), 1);
      chk(cpu_clk_en == 1'b1, "R11 run in reset", int'(cpu_clk_en), 1);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(reg_rst_pulse == 1'b0, "R11 pulse cleared", int'(reg_rst_pulse), 0);
   endtask

   task automatic enter(input bit stop);
      @(negedge clk);
      if (stop) stop_req = 1'b1; else sleep_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0; sleep_req = 1'b0;
   endtask

   // count edges until cpu clock resumes; 0 when it does not within lim
   task automatic wait_wake(input int lim, output int n, output bit rdy);
      n = 0; rdy = 1'b0;
      for (int k = 1; k <= lim; k++) begin
         @(posedge clk); #1;
         if (reg_rst_pulse) chk(1'b0, "R11 pulse on irq wake", 1, 0);
         if (cpu_clk_en) begin n = k; rdy = clk_ready; break; end
      end
   endtask

   initial begin
      int  n;
      bit  rdy;
      bit  exp_wake;
      do_reset();
      chk(osc_main_en && cpu_clk_en && bit_clk_en && evt_clk_en, "R3 run gates", int'(cpu_clk_en), 1);
      chk(clk_ready == 1'b0, "R9 ready idle", int'(clk_ready), 0);

      // stop sweep: period select x external mode x source
      for (int sel = 0; sel < 4; sel++) begin
         for (int ext = 0; ext < 2; ext++) begin
            for (int s = 0; s < N; s++) begin
               do_reset();
               @(negedge clk);
               irq_en = N'(1) << s; warm_sel = 2'(sel); evt_ext_mode = ext[0];
               enter(1'b1);
               chk(!osc_main_en && !cpu_clk_en && !bit_clk_en, "R1 stop gates", int'(osc_main_en), 0);
               chk(evt_clk_en == ext[0], "R4 evt gate in stop", int'(evt_clk_en), ext);
               chk(watch_clk_en && lcd_clk_en, "R3 stop always-on", int'(watch_clk_en), 1);
               evt_ext_mode = ~ext[0];
               irq_req = N'(1) << s;
               exp_wake = (s == 0) || (s == 1) || (s == 4) || (((s == 2) || (s == 3)) && (ext == 1));
               wait_wake(40, n, rdy);
               if (exp_wake) begin
                  chk(n == (BSE << sel) + 1, "R8 warm-up latency", n, (BSE << sel) + 1);
                  chk(rdy == 1'b1, "R9 ready at resume", int'(rdy), 1);
                  @(posedge clk); #1;
                  chk(clk_ready == 1'b0, "R9 ready one cycle", int'(clk_ready), 0);
               end else begin
                  chk(n == 0, "R5 source must not wake stop", n, 0);
                  chk(evt_clk_en == ext[0], "R4 evt gate held", int'(evt_clk_en), ext);
               end
               @(negedge clk); irq_req = '0;
            end
         end
      end

      // sleep sweep
      for (int s = 0; s < N; s++) begin
         do_reset();
         @(negedge clk); irq_en = N'(1) << s;
         enter(1'b0);
         chk(!cpu_clk_en && osc_main_en && bit_clk_en && evt_clk_en, "R2 sleep gates", int'(cpu_clk_en), 0);
         chk(watch_clk_en && lcd_clk_en, "R3 sleep always-on", int'(lcd_clk_en), 1);
         irq_req = N'(1) << s;
         wait_wake(10, n, rdy);
         chk(n == 1, "R6 sleep wake latency", n, 1);
         chk(rdy == 1'b0, "R9 no ready on sleep wake", int'(rdy), 0);
         @(negedge clk); irq_req = '0;
      end

      // R7: enables set after entry are ignored; reset exits (R11)
      do_reset();
      enter(1'b0);
      irq_en = '1; irq_req = '1;
      wait_wake(10, n, rdy);
      chk(n == 0, "R7 late enable ignored", n, 0);
      do_reset();
      chk(cpu_clk_en == 1'b1, "R11 reset leaves sleep", int'(cpu_clk_en), 1);

      // R10: request dropped while an enabled interrupt is pending
      @(negedge clk); irq_en = 6'b000001; irq_req = 6'b000001;
      enter(1'b1);
      chk(cpu_clk_en && osc_main_en, "R10 request dropped", int'(osc_main_en), 1);
      irq_req = '0;
      @(negedge clk); stop_req = 1'b1; sleep_req = 1'b1;
      @(negedge clk); stop_req = 1'b0; sleep_req = 1'b0;
      chk(osc_main_en == 1'b0, "R10 stop wins over sleep", int'(osc_main_en), 0);

      // R8: tick gaps stall the warm-up
      do_reset();
      @(negedge clk); irq_en = 6'b000010; warm_sel = 2'd0;
      enter(1'b1);
      sub_tick = 1'b0; irq_req = 6'b000010;
      repeat (6) @(posedge clk);
      #1;
      chk(cpu_clk_en == 1'b0, "R8 held without ticks", int'(cpu_clk_en), 0);
      chk(osc_main_en == 1'b1, "R8 oscillator on in warm-up", int'(osc_main_en), 1);
      @(negedge clk); sub_tick = 1'b1;
      wait_wake(20, n, rdy);
      chk(n == BSE, "R8 ticks only counted", n, BSE);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule